// File: doc/BRIEF.md
# Wait/DMA Request Pin Controller

This block drives the shared wait/request pin of one serial channel. Three configuration bits choose what the pin does. One bit turns the function on. One bit picks between a CPU stall (wait) and a DMA transfer request. One bit makes the pin follow either the receive buffer or the transmit buffer. In wait mode the pin is released until the CPU attempts a data access that cannot be honoured yet. Such an access is a read with nothing received, or a write while the transmit buffer is still occupied. The pin is then pulled low. In request mode the pin is driven high while idle and goes low whenever the tracked buffer can move a byte. A DMA controller then performs the access.

The pin is open-drain in wait mode. It is therefore brought out as a drive-low enable plus a float indication. A separate active-low request level mirrors the pin in request mode. A request never reaches the pin while the chip is selected. It waits until the current bus cycle has ended. When the transmitter reports the end of a CRC in a synchronous framing mode, and the pin is requesting on transmit, it is pulsed low for one clock. All outputs come from registers clocked by the channel clock. The receive fill level and the transmit-empty flag come from buffer logic outside this block.

Top module: `wreq_pin_ctrl`

## Requirements
- R1: With `cfg_enable` = 0, one clock after sampling, the pin is inactive. If `cfg_req_sel` = 1 it is driven high (`pin_low` = 0, `pin_float` = 0, `dma_req_n` = 1). If `cfg_req_sel` = 0 it is released (`pin_float` = 1, `pin_low` = 0).
- R2: In request mode (`cfg_enable` = 1, `cfg_req_sel` = 1) with `cfg_rx_track` = 1, a nonzero `rx_level` sampled while `bus_cs` = 0 drives `pin_low` = 1 and `dma_req_n` = 0 one clock later. A zero level keeps the request off.
- R3: In request mode with `cfg_rx_track` = 0, the request follows `tx_empty` = 1 in the same way.
- R4: In wait mode (`cfg_enable` = 1, `cfg_req_sel` = 0) with `cfg_rx_track` = 1, a clock that samples `bus_cs` = 1, `bus_rd` = 1 and `rx_level` = 0 gives `pin_low` = 1 and `pin_float` = 0 one clock later. Otherwise the pin floats.
- R5: In wait mode with `cfg_rx_track` = 0, a clock that samples `bus_cs` = 1, `bus_wr` = 1 and `tx_empty` = 0 pulls the pin low one clock later.
- R6: While `bus_cs` = 1, an inactive request stays inactive, even if the tracked buffer becomes ready. It can rise only one clock after a clock that samples `bus_cs` = 0.
- R7: A serving access drops an active request one clock later. The serving access is `bus_cs`&`bus_rd` when tracking receive, or `bus_cs`&`bus_wr` when tracking transmit.
- R8: In request mode with `cfg_rx_track` = 0 and `cfg_sync_frame` = 1, a rising edge of `crc_end` drives the pin low for exactly one clock, however long `crc_end` stays high. The edge has no effect when `cfg_sync_frame` = 0 or when tracking receive.
- R9: During and after reset, before any mode is applied, `pin_low` = 0, `pin_float` = 1 and `dma_req_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Enables the wait/request function |
| cfg_req_sel | input | 1 | 1 = DMA request mode, 0 = wait mode |
| cfg_rx_track | input | 1 | 1 = follow receive buffer, 0 = follow transmit buffer |
| cfg_sync_frame | input | 1 | Channel runs a synchronous/framed protocol |
| bus_cs | input | 1 | Chip select of the CPU bus cycle |
| bus_rd | input | 1 | Data read strobe |
| bus_wr | input | 1 | Data write strobe |
| rx_level | input | RX_CNT_W | Characters held in the receive buffer |
| tx_empty | input | 1 | Transmit buffer is empty |
| crc_end | input | 1 | Transmitter has finished sending a CRC |
| pin_low | output | 1 | Drive the pin low |
| pin_float | output | 1 | Pin released (wait mode, idle) |
| dma_req_n | output | 1 | Active-low request level |

## Verification
The bench builds the block with `RX_CNT_W` = 2. The receive level then spans only 0 to 3, so the empty and full fill levels, and every level between them, recur many times during the random phase. This width also exercises the rule that any nonzero level counts as ready. A behavioural model is compared every clock while the three mode bits, chip select, strobes and buffer state are varied. This covers request rises deferred by long chip-select stretches, and CRC edges arriving both during and outside request-on-transmit.

// File: rtl/wreq_pkg.sv
package wreq_pkg;

    typedef struct packed {
        logic enable;
        logic req_sel;
        logic rx_track;
    } wreq_mode_t;

    typedef struct packed {
        logic cs;
        logic rd;
        logic wr;
    } wreq_bus_t;

endpackage

// File: rtl/wreq_wait_gen.sv
module wreq_wait_gen
    import wreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wreq_mode_t mode,
    input  wreq_bus_t  bus,
    input  logic       rx_ready,
    input  logic       tx_empty,
    output logic       wait_low,
    output logic       wait_float
);

    typedef struct packed {
        logic low;
        logic flt;
    } state_t;

    state_t st_d, st_q;
    logic   stall_rx, stall_tx, wait_mode;

    always_comb begin
        wait_mode = mode.enable & ~mode.req_sel;
        stall_rx  = mode.rx_track  & bus.cs & bus.rd & ~rx_ready;
        stall_tx  = ~mode.rx_track & bus.cs & bus.wr & ~tx_empty;
        st_d.low  = wait_mode & (stall_rx | stall_tx);
        // request function selected: pin driven high, never released
        st_d.flt  = ~mode.req_sel & ~st_d.low;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.low <= 1'b0;
            st_q.flt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wait_low   = st_q.low;
    assign wait_float = st_q.flt;

endmodule

// File: rtl/wreq_req_gen.sv
module wreq_req_gen
    import wreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wreq_mode_t mode,
    input  wreq_bus_t  bus,
    input  logic       rx_ready,
    input  logic       tx_empty,
    output logic       req_act
);

    logic req_d, req_q;
    logic ready, served, req_mode;

    always_comb begin
        req_mode = mode.enable & mode.req_sel;
        ready    = mode.rx_track ? rx_ready : tx_empty;
        served   = bus.cs & (mode.rx_track ? bus.rd : bus.wr);
        // hold an active request; start a new one only outside a bus cycle
        req_d    = req_mode & ready & ~served & (req_q | ~bus.cs);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign req_act = req_q;

endmodule

// File: rtl/wreq_crc_pulse.sv
module wreq_crc_pulse
    import wreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wreq_mode_t mode,
    input  logic       sync_frame,
    input  logic       crc_end,
    output logic       pulse
);

    typedef struct packed {
        logic prev;
        logic pls;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d.prev = crc_end;
        st_d.pls  = mode.enable & mode.req_sel & ~mode.rx_track & sync_frame
                  & crc_end & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pls;

endmodule

// File: rtl/wreq_pin_ctrl.sv
module wreq_pin_ctrl
    import wreq_pkg::*;
#(
    parameter int RX_CNT_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_enable,
    input  logic                cfg_req_sel,
    input  logic                cfg_rx_track,
    input  logic                cfg_sync_frame,
    input  logic                bus_cs,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [RX_CNT_W-1:0] rx_level,
    input  logic                tx_empty,
    input  logic                crc_end,
    output logic                pin_low,
    output logic                pin_float,
    output logic                dma_req_n
);

    wreq_mode_t mode;
    wreq_bus_t  bus;
    logic       rx_ready;
    logic       wait_low, wait_float, req_act, crc_pls;

    always_comb begin
        mode.enable   = cfg_enable;
        mode.req_sel  = cfg_req_sel;
        mode.rx_track = cfg_rx_track;
        bus.cs        = bus_cs;
        bus.rd        = bus_rd;
        bus.wr        = bus_wr;
        rx_ready      = |rx_level;
    end

    wreq_wait_gen u_wait (
        .clk(clk), .rst_n(rst_n), .mode(mode), .bus(bus),
        .rx_ready(rx_ready), .tx_empty(tx_empty),
        .wait_low(wait_low), .wait_float(wait_float)
    );

    wreq_req_gen u_req (
        .clk(clk), .rst_n(rst_n), .mode(mode), .bus(bus),
        .rx_ready(rx_ready), .tx_empty(tx_empty),
        .req_act(req_act)
    );

    wreq_crc_pulse u_crc (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .sync_frame(cfg_sync_frame), .crc_end(crc_end),
        .pulse(crc_pls)
    );

    assign pin_low   = wait_low | req_act | crc_pls;
    assign pin_float = wait_float;
    assign dma_req_n = ~(req_act | crc_pls);

endmodule

// File: rtl/wreq_pin_ctrl_chk.sv
module wreq_pin_ctrl_chk #(
    parameter int RX_CNT_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_enable,
    input logic                cfg_req_sel,
    input logic                cfg_rx_track,
    input logic                bus_cs,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic [RX_CNT_W-1:0] rx_level,
    input logic                tx_empty,
    input logic                crc_end,
    input logic                pin_low,
    input logic                pin_float,
    input logic                dma_req_n
);

    AST_OFF_DRIVEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && cfg_req_sel) |=> (!pin_low && !pin_float && dma_req_n)); // R1

    AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !cfg_req_sel) |=> (pin_float && !pin_low)); // R1

    AST_WAIT_ON_EMPTY_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !cfg_req_sel && cfg_rx_track && bus_cs && bus_rd && rx_level == '0)
        |=> (pin_low && !pin_float)); // R4

    AST_WAIT_ON_FULL_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !cfg_req_sel && !cfg_rx_track && bus_cs && bus_wr && !tx_empty)
        |=> (pin_low && !pin_float)); // R5

    AST_DEFER_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && dma_req_n && !crc_end) |=> dma_req_n); // R6

    AST_SERVED_RX_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rx_track && bus_cs && bus_rd) |=> dma_req_n); // R7

    AST_FLOAT_NOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pin_float |-> !pin_low); // R1

endmodule

bind wreq_pin_ctrl wreq_pin_ctrl_chk #(.RX_CNT_W(RX_CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_req_sel(cfg_req_sel),
    .cfg_rx_track(cfg_rx_track), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .rx_level(rx_level), .tx_empty(tx_empty), .crc_end(crc_end),
    .pin_low(pin_low), .pin_float(pin_float), .dma_req_n(dma_req_n)
);

// File: tb/wreq_pin_ctrl_tb.sv
module wreq_pin_ctrl_tb_top;

    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 0, rsel = 0, rxt = 0, sync = 0;
    logic         cs = 0, rd = 0, wr = 0, txe = 0, crc = 0;
    logic [W-1:0] lvl = '0;
    logic         pin_low, pin_float, dma_req_n;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wreq_pin_ctrl #(.RX_CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_req_sel(rsel),
        .cfg_rx_track(rxt), .cfg_sync_frame(sync), .bus_cs(cs), .bus_rd(rd),
        .bus_wr(wr), .rx_level(lvl), .tx_empty(txe), .crc_end(crc),
        .pin_low(pin_low), .pin_float(pin_float), .dma_req_n(dma_req_n)
    );

    // behavioural reference: expected pin state after each clock
    bit m_req, m_stall, m_pulse, m_float, m_crc_seen;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_req <= 0; m_stall <= 0; m_pulse <= 0; m_float <= 1; m_crc_seen <= 0;
        end else begin
            bit have, serve, stall;
            have  = rxt ? (int'(lvl) > 0) : (txe == 1'b1);
            serve = cs && (rxt ? rd : wr);
            stall = cs && (rxt ? (rd && int'(lvl) == 0) : (wr && !txe));
            if (!(en && rsel) || serve || !have) m_req <= 0;
            else if (!cs)                        m_req <= 1;
            m_stall    <= en && !rsel && stall;
            m_float    <= !rsel && !(en && stall);
            m_pulse    <= en && rsel && !rxt && sync && crc && !m_crc_seen;
            m_crc_seen <= crc;
        end
    end

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s {low,float,req_n} actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            string tag;
            if (!en)       tag = "R1";
            else if (rsel) tag = rxt ? "R2" : "R3";
            else           tag = rxt ? "R4" : "R5";
            chk({tag, " model"}, {pin_low, pin_float, dma_req_n},
                {m_stall || m_req || m_pulse, m_float, !(m_req || m_pulse)});
        end
    end

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_idle();
        cs = 0; rd = 0; wr = 0;
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        cyc(3);
        chk("R9 reset", {pin_low, pin_float, dma_req_n}, 3'b011);
        rst_n = 1;
        cyc(1);
        chk("R9 after reset", {pin_low, pin_float, dma_req_n}, 3'b011);
        cmp_on = 1;

        // R1 disabled
        en = 0; rsel = 1; lvl = 2'd3; txe = 1; cyc(2);
        chk("R1 off request", {pin_low, pin_float, dma_req_n}, 3'b001);
        rsel = 0; cs = 1; rd = 1; lvl = 0; cyc(1);
        chk("R1 off wait", {pin_low, pin_float, dma_req_n}, 3'b011);
        bus_idle();

        // R4 wait on receive
        en = 1; rsel = 0; rxt = 1; lvl = 0; cyc(1);
        cs = 1; rd = 1; cyc(1);
        chk("R4 stall read", {pin_low, pin_float}, 2'b10);
        lvl = 2'd1; cyc(1);
        chk("R4 data arrived", {pin_low, pin_float}, 2'b01);
        bus_idle(); cyc(1);

        // R5 wait on transmit
        rxt = 0; txe = 0; cs = 1; wr = 1; cyc(1);
        chk("R5 stall write", {pin_low, pin_float}, 2'b10);
        txe = 1; cyc(1);
        chk("R5 buffer free", {pin_low, pin_float}, 2'b01);
        bus_idle(); cyc(1);

        // R2 request on receive, R7 drop after read
        rsel = 1; rxt = 1; lvl = 0; cyc(2);
        chk("R2 nothing held", {pin_low, dma_req_n}, 2'b01);
        lvl = 2'd2; cyc(1);
        chk("R2 request", {pin_low, dma_req_n}, 2'b10);
        cs = 1; rd = 1; cyc(1);
        chk("R7 served read", {pin_low, dma_req_n}, 2'b01);
        bus_idle(); lvl = 2'd1; cyc(1);
        chk("R2 re-request", dma_req_n, 1'b0);
        lvl = 0; cyc(1);
        chk("R2 drained", dma_req_n, 1'b1);

        // R6 defer while selected
        cs = 1; cyc(1);
        lvl = 2'd3; cyc(3);
        chk("R6 held off", dma_req_n, 1'b1);
        cs = 0; cyc(1);
        chk("R6 released", dma_req_n, 1'b0);

        // R3 request on transmit, R7 via write
        rxt = 0; txe = 1; cyc(1);
        chk("R3 tx request", dma_req_n, 1'b0);
        cs = 1; wr = 1; txe = 0; cyc(1);
        chk("R7 served write", dma_req_n, 1'b1);
        bus_idle(); cyc(1);
        chk("R3 tx full idle", dma_req_n, 1'b1);

        // R8 end-of-CRC pulse
        sync = 1; crc = 1; cyc(1);
        chk("R8 pulse", {pin_low, dma_req_n}, 2'b10);
        cyc(1);
        chk("R8 single clock", {pin_low, dma_req_n}, 2'b01);
        crc = 0; cyc(1);
        sync = 0; crc = 1; cyc(1);
        chk("R8 async no pulse", dma_req_n, 1'b1);
        crc = 0; cyc(1);
        sync = 1; rxt = 1; lvl = 0; crc = 1; cyc(1);
        chk("R8 rx track no pulse", dma_req_n, 1'b1);
        crc = 0; cyc(1);

        // random phase, model comparison each clock
        for (int i = 0; i < 3000; i++) begin
            if (i % 37 == 0) begin
                en = $urandom_range(0, 3) != 0;
                rsel = $urandom_range(0, 1);
                rxt = $urandom_range(0, 1);
                sync = $urandom_range(0, 1);
            end
            cs  = $urandom_range(0, 2) == 0;
            rd  = cs && $urandom_range(0, 1);
            wr  = cs && !rd && $urandom_range(0, 1);
            lvl = W'($urandom_range(0, 3));
            txe = $urandom_range(0, 1);
            crc = $urandom_range(0, 5) == 0;
            cyc(1);
        end

        finished = 1;
        report();
    end

endmodule